// File: doc/BRIEF.md
# Write-Leveling Edge Search Engine

This block places the write strobe of every byte lane on the clock edge that the memory device observes. The memory sends back one feedback bit per lane. That bit reads high when the strobe lands after the clock edge and low when it lands before it. The engine drives one step-up and one step-down command per lane to external delay steppers. It reads back whether each stepper is at its lowest or highest setting. It reports the end of the search with a done pulse, or reports a held error flag.

A search begins on a start pulse. The engine first tells the steppers to reload their stored safe settings. It then runs a descending phase: every lane is stepped down until none of its samples read high. An ascending phase follows: every lane is stepped up until all of its samples read high. After both phases, each lane sits on a low-to-high transition. Each evaluation round issues a fixed number of sample triggers. Every trigger is followed by a settle wait, and then one feedback capture per lane.

The engine has no streaming data path. Every pin is a plain level or single-cycle pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `wl_edge_search`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `seed_load`, `smp_trig` and all step outputs are low.
- R2: A `start` pulse while idle makes `seed_load` pulse for exactly one cycle, in the cycle after the start cycle. A `start` while `busy` is high is ignored, so `seed_load` pulses once per search.
- R3: An evaluation round issues N_SMP = 5 `smp_trig` pulses. Every lane's high-sample counter (3 bits) is cleared at the first trigger of the round. `fb_bits` is captured in the cycle that lies SETTLE_CYC + 1 cycles after the trigger cycle. Consecutive triggers within a round are therefore SETTLE_CYC + 2 cycles apart.
- R4: In the descending phase, a lane whose count is above 0 gets a one-cycle `step_dn` pulse. A lane whose count is 0 is marked finished and is not stepped again in that phase.
- R5: The ascending phase starts with every lane unmarked. A lane whose count is below 5 gets a one-cycle `step_up` pulse. A lane whose count equals 5 is marked finished.
- R6: Each phase repeats rounds until all eight lanes are marked. For a clean edge, a lane ends at the first setting that reads high, and the number of down and up steps follows from its start setting and that edge.
- R7: If, in the descending phase, a lane needs a down step while its `at_min` is high, the search aborts. In that decision cycle no step pulse is issued on any lane, `busy` falls, and `err` rises and stays high until the next accepted `start`.
- R8: If, in the ascending phase, a lane needs an up step while its `at_max` is high, the search aborts in the same way as in R7.
- R9: A successful search ends with exactly one single-cycle `done` pulse. That pulse is the cue for the steppers to store their present settings as the new strobe values. No `done` pulse occurs on an aborted search.
- R10: `step_up` and `step_dn` are never both high on a lane. No step is ever issued toward a stepper that reports being at that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a search while idle |
| fb_bits | input | LANES | Per-lane feedback bit sampled from the memory |
| at_min | input | LANES | Stepper reports its lowest setting |
| at_max | input | LANES | Stepper reports its highest setting |
| seed_load | output | 1 | Steppers reload the stored safe setting |
| smp_trig | output | 1 | Trigger a feedback sample |
| step_up | output | LANES | Per-lane one-cycle step-up command |
| step_dn | output | LANES | Per-lane one-cycle step-down command |
| busy | output | 1 | Search in progress |
| done | output | 1 | Single-cycle pulse on successful completion; steppers store settings |
| err | output | 1 | Search aborted at a stepper limit; held until next start |

## Verification
The hardest situation to reach from the ports is a lane whose sample count lands strictly between 0 and 5. That count must keep the lane stepping in both phases. The bench models a feedback bit that alternates between triggers when a lane sits exactly on its edge, which drives that lane one setting past the edge. The bench also reaches the limit aborts by placing an edge at setting 0, or one past the top setting. Finally, it makes the feedback deliberately wrong until the exact capture cycle. With that model, any capture taken before the settle wait expires produces wrong settings.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_TRIG,
    ST_WAIT,
    ST_CAPT,
    ST_DECIDE,
    ST_NEXTPH,
    ST_FIN
  } wl_state_e;

  typedef enum logic {
    PH_DESCEND = 1'b0,
    PH_ASCEND  = 1'b1
  } wl_phase_e;

endpackage

// File: rtl/wl_seq.sv
module wl_seq
  import wl_pkg::*;
#(
  parameter int N_SMP      = 5,
  parameter int SETTLE_CYC = 625
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      all_done_nxt,
  input  logic      abort_nxt,
  output wl_phase_e phase,
  output logic      smp_trig,
  output logic      clr_cnt,
  output logic      capt,
  output logic      decide,
  output logic      mask_clr,
  output logic      seed_load,
  output logic      busy,
  output logic      done,
  output logic      err
);

  localparam int TW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam int SW = (N_SMP < 2) ? 1 : $clog2(N_SMP);
  localparam logic [TW-1:0] TMR_LAST = TW'(SETTLE_CYC - 1);
  localparam logic [SW-1:0] SMP_LAST = SW'(N_SMP - 1);

  wl_state_e     state_q;
  logic [TW-1:0] tmr_q;
  logic [SW-1:0] sidx_q;
  wl_phase_e     phase_q;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      sidx_q  <= '0;
      phase_q <= PH_DESCEND;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SEED;
            err_q   <= 1'b0;
          end
        end
        ST_SEED: begin
          state_q <= ST_TRIG;
          sidx_q  <= '0;
          phase_q <= PH_DESCEND;
        end
        ST_TRIG: begin
          state_q <= ST_WAIT;
          tmr_q   <= '0;
        end
        ST_WAIT: begin
          if (tmr_q == TMR_LAST) state_q <= ST_CAPT;
          else tmr_q <= tmr_q + 1'b1;
        end
        ST_CAPT: begin
          if (sidx_q == SMP_LAST) begin
            state_q <= ST_DECIDE;
          end else begin
            sidx_q  <= sidx_q + 1'b1;
            state_q <= ST_TRIG;
          end
        end
        ST_DECIDE: begin
          sidx_q <= '0;
          if (abort_nxt) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else if (all_done_nxt) begin
            state_q <= (phase_q == PH_DESCEND) ? ST_NEXTPH : ST_FIN;
          end else begin
            state_q <= ST_TRIG;
          end
        end
        ST_NEXTPH: begin
          phase_q <= PH_ASCEND;
          state_q <= ST_TRIG;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phase     = phase_q;
  assign smp_trig  = (state_q == ST_TRIG);
  assign clr_cnt   = (state_q == ST_TRIG) && (sidx_q == '0);
  assign capt      = (state_q == ST_CAPT);
  assign decide    = (state_q == ST_DECIDE);
  assign mask_clr  = (state_q == ST_SEED) || (state_q == ST_NEXTPH);
  assign seed_load = (state_q == ST_SEED);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err       = err_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  capt_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && tmr_q == TMR_LAST) |=> (state_q == ST_CAPT));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(state_q == ST_IDLE && start)) |=> err);

  // R2
  seed_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !seed_load);

endmodule

// File: rtl/wl_sample_acc.sv
module wl_sample_acc #(
  parameter int LANES = 8,
  parameter int N_SMP = 5,
  localparam int CW   = $clog2(N_SMP + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      capt,
  input  logic [LANES-1:0]          fb,
  output logic [LANES-1:0][CW-1:0]  cnt
);

  localparam logic [CW-1:0] FULL = CW'(N_SMP);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else if (clr) begin
        acc_q <= '0;
      end else if (capt && fb[g]) begin
        acc_q <= acc_q + 1'b1;
      end
    end

    assign cnt[g] = acc_q;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= FULL);
  end

endmodule

// File: rtl/wl_lane_ctl.sv
module wl_lane_ctl
  import wl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int N_SMP = 5,
  localparam int CW   = $clog2(N_SMP + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     decide,
  input  logic                     mask_clr,
  input  wl_phase_e                phase,
  input  logic [LANES-1:0][CW-1:0] cnt,
  input  logic [LANES-1:0]         at_min,
  input  logic [LANES-1:0]         at_max,
  output logic [LANES-1:0]         step_up,
  output logic [LANES-1:0]         step_dn,
  output logic                     all_done_nxt,
  output logic                     abort_nxt
);

  localparam logic [CW-1:0] FULL = CW'(N_SMP);

  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] want_up, want_dn, blocked, fin, mask_nxt;
  logic [LANES-1:0] up_q, dn_q;

  for (genvar g = 0; g < LANES; g++) begin : g_dec
    always_comb begin
      want_dn[g] = !mask_q[g] && (phase == PH_DESCEND) && (cnt[g] != '0);
      want_up[g] = !mask_q[g] && (phase == PH_ASCEND) && (cnt[g] != FULL);
      blocked[g] = (want_dn[g] && at_min[g]) || (want_up[g] && at_max[g]);
      fin[g]     = !mask_q[g] &&
                   ((phase == PH_DESCEND) ? (cnt[g] == '0) : (cnt[g] == FULL));
    end
  end

  assign mask_nxt     = mask_q | fin;
  assign abort_nxt    = |blocked;
  assign all_done_nxt = &mask_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      up_q   <= '0;
      dn_q   <= '0;
    end else begin
      up_q <= '0;
      dn_q <= '0;
      if (mask_clr) begin
        mask_q <= '0;
      end else if (decide && !abort_nxt) begin
        mask_q <= mask_nxt;
        up_q   <= want_up;
        dn_q   <= want_dn;
      end
    end
  end

  assign step_up = up_q;
  assign step_dn = dn_q;

  // R10
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up & step_dn) == '0);

  // R4
  finished_lane_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_up | step_dn) & mask_q) == '0);

  // R5
  no_up_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DESCEND) |-> (step_up == '0));

endmodule

// File: rtl/wl_edge_search.sv
module wl_edge_search
  import wl_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int N_SMP      = 5,
  parameter int SETTLE_CYC = 625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LANES-1:0] fb_bits,
  input  logic [LANES-1:0] at_min,
  input  logic [LANES-1:0] at_max,
  output logic             seed_load,
  output logic             smp_trig,
  output logic [LANES-1:0] step_up,
  output logic [LANES-1:0] step_dn,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam int CW = $clog2(N_SMP + 1);

  wl_phase_e                phase;
  logic                     clr_cnt, capt, decide, mask_clr;
  logic                     all_done_nxt, abort_nxt;
  logic [LANES-1:0][CW-1:0] cnt;

  wl_seq #(.N_SMP(N_SMP), .SETTLE_CYC(SETTLE_CYC)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .all_done_nxt (all_done_nxt),
    .abort_nxt    (abort_nxt),
    .phase        (phase),
    .smp_trig     (smp_trig),
    .clr_cnt      (clr_cnt),
    .capt         (capt),
    .decide       (decide),
    .mask_clr     (mask_clr),
    .seed_load    (seed_load),
    .busy         (busy),
    .done         (done),
    .err          (err)
  );

  wl_sample_acc #(.LANES(LANES), .N_SMP(N_SMP)) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_cnt),
    .capt  (capt),
    .fb    (fb_bits),
    .cnt   (cnt)
  );

  wl_lane_ctl #(.LANES(LANES), .N_SMP(N_SMP)) ctl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .decide       (decide),
    .mask_clr     (mask_clr),
    .phase        (phase),
    .cnt          (cnt),
    .at_min       (at_min),
    .at_max       (at_max),
    .step_up      (step_up),
    .step_dn      (step_dn),
    .all_done_nxt (all_done_nxt),
    .abort_nxt    (abort_nxt)
  );

  // R10
  no_step_below_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn & at_min) == '0);

  // R10
  no_step_above_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up & at_max) == '0);

  // R9
  done_not_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !err);

endmodule

// File: tb/wl_edge_search_tb_top.sv
module wl_edge_search_tb_top;

  localparam int LANES  = 8;
  localparam int SETTLE = 6;
  localparam int PMAX   = 31;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LANES-1:0] fb_bits, at_min, at_max;
  logic             seed_load, smp_trig, busy, done, err;
  logic [LANES-1:0] step_up, step_dn;

  always #4 clk = ~clk;

  wl_edge_search #(.LANES(LANES), .N_SMP(5), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_bits(fb_bits),
    .at_min(at_min), .at_max(at_max), .seed_load(seed_load),
    .smp_trig(smp_trig), .step_up(step_up), .step_dn(step_dn),
    .busy(busy), .done(done), .err(err)
  );

  int  n_chk = 0, n_fail = 0;
  int  pos [LANES];
  int  spos[LANES];
  int  edg [LANES];
  bit  fz  [LANES];
  int  ups [LANES];
  int  dns [LANES];
  int  since = 1000, tcount = 0, last_trig = -1, min_gap = 1000000;
  int  cyc = 0, seeds = 0, dones = 0, illegal = 0, trigs = 0;

  function automatic logic model_bit(int p, int e, bit f, bit tog);
    if (f) return (p > e) ? 1'b1 : ((p == e) ? tog : 1'b0);
    return (p >= e);
  endfunction

  function automatic int exp_target(int e, bit f);
    return e + int'(f);
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic b;
      b = model_bit(pos[i], edg[i], fz[i], tcount[0]);
      fb_bits[i] = (since > SETTLE) ? b : ~b;
      at_min[i]  = (pos[i] == 0);
      at_max[i]  = (pos[i] == PMAX);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (smp_trig) begin
      since  <= 1;
      tcount <= tcount + 1;
      trigs  <= trigs + 1;
      if (last_trig >= 0 && (cyc - last_trig) < min_gap) min_gap <= cyc - last_trig;
      last_trig <= cyc;
    end else if (since < 1000) begin
      since <= since + 1;
    end
    if (seed_load) seeds <= seeds + 1;
    if (done) dones <= dones + 1;
    for (int i = 0; i < LANES; i++) begin
      if (step_up[i] && step_dn[i]) illegal <= illegal + 1;
      if ((step_dn[i] && pos[i] == 0) || (step_up[i] && pos[i] == PMAX)) illegal <= illegal + 1;
      if (seed_load) begin
        pos[i] <= spos[i];
      end else begin
        if (step_up[i]) begin pos[i] <= pos[i] + 1; ups[i] <= ups[i] + 1; end
        if (step_dn[i]) begin pos[i] <= pos[i] - 1; dns[i] <= dns[i] + 1; end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_search(bit poke_busy);
    int guard;
    for (int i = 0; i < LANES; i++) begin ups[i] = 0; dns[i] = 0; end
    seeds = 0; dones = 0; trigs = 0; last_trig = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: seed_load in the cycle after start
    check("R2 seed_load after start", int'(seed_load), 1);
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (poke_busy && guard == 50) start = 1'b1;
      if (poke_busy && guard == 51) start = 1'b0;
    end
    if (guard >= 20000) check("watchdog trial", 0, 1);
    @(negedge clk);
  endtask

  task automatic verify_trial(string tag);
    bit exp_err = 0;
    for (int i = 0; i < LANES; i++)
      if (edg[i] == 0 || exp_target(edg[i], fz[i]) > PMAX) exp_err = 1;
    // R7 R8
    check({tag, " R7/R8 err flag"}, int'(err), int'(exp_err));
    // R9
    check({tag, " R9 done pulses"}, dones, exp_err ? 0 : 1);
    check({tag, " R2 single seed"}, seeds, 1);
    // R3
    check({tag, " R3 triggers per round"}, trigs % 5, 0);
    // R10
    check({tag, " R10 illegal steps"}, illegal, 0);
    if (!exp_err) begin
      for (int i = 0; i < LANES; i++) begin
        int low, tgt;
        tgt = exp_target(edg[i], fz[i]);
        low = (spos[i] >= edg[i]) ? edg[i] - 1 : spos[i];
        // R6
        check({tag, " R6 final setting"}, pos[i], tgt);
        // R4
        check({tag, " R4 down steps"}, dns[i], spos[i] - low);
        // R5
        check({tag, " R5 up steps"}, ups[i], tgt - low);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < LANES; i++) begin
      pos[i] = 10; spos[i] = 10; edg[i] = 12; fz[i] = 0; ups[i] = 0; dns[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset outputs", int'({busy, done, err, seed_load, smp_trig, |step_up, |step_dn}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(busy), 0);

    // directed: all lanes start below edge, no descend steps (R4)
    for (int i = 0; i < LANES; i++) begin spos[i] = 2 + i; edg[i] = 15; fz[i] = 0; end
    run_search(1'b1);
    verify_trial("below");
    check("R3 trigger spacing", min_gap, SETTLE + 2);

    // directed: mixed, with fuzzy lanes whose counts sit between 0 and 5
    for (int i = 0; i < LANES; i++) begin spos[i] = 25 - i; edg[i] = 5 + 2 * i; fz[i] = i[0]; end
    run_search(1'b0);
    verify_trial("fuzzy");

    // directed: edge at 0 forces descend at minimum (R7)
    for (int i = 0; i < LANES; i++) begin spos[i] = 8; edg[i] = 9; fz[i] = 0; end
    edg[3] = 0;
    run_search(1'b0);
    verify_trial("minabort");
    check("R7 busy low after abort", int'(busy), 0);

    // directed: edge past top forces ascend at maximum (R8)
    for (int i = 0; i < LANES; i++) begin spos[i] = 20; edg[i] = 22; fz[i] = 0; end
    edg[6] = PMAX; fz[6] = 1;
    run_search(1'b0);
    verify_trial("maxabort");

    // lane already fully low at minimum: no abort (R4)
    for (int i = 0; i < LANES; i++) begin spos[i] = 0; edg[i] = 3; fz[i] = 0; end
    run_search(1'b0);
    verify_trial("zerostart");

    // constrained random trials
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < LANES; i++) begin
        int r;
        spos[i] = int'($urandom_range(0, PMAX));
        edg[i]  = int'($urandom_range(1, PMAX - 1));
        fz[i]   = bit'($urandom_range(0, 1));
        r = int'($urandom_range(0, 63));
        if (r == 0) edg[i] = 0;
        if (r == 1) edg[i] = PMAX + 1;
      end
      run_search(bit'(t % 3 == 0));
      verify_trial("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule